// File: doc/BRIEF.md
# Serial Command and Status Port

This block is the slave side of a four-wire serial link that carries switch commands into a power-stage controller and carries status back out. A frame opens when the active-low select goes low. During the frame the master clocks in a 16-bit command word and, over the same clock edges, reads back a 16-bit status word. Both words travel least-significant bit first. The port samples incoming bits on falling serial-clock edges and updates the outgoing bit on rising edges. The status word is captured once, when the frame opens, so the bits read back all come from the same instant.

The command is applied to the control register only when the select returns high, and only if exactly 16 falling clock edges arrived during the frame. A small set of reserved words is never applied. When one arrives, a sticky flag records it. All three serial inputs are synchronised into the system clock domain, and that clock must run at least eight times faster than the serial clock. The serial data output is driven only while a frame is open. Outside a frame the enable is low and the data line reads 0, so the pad can float.

Top module: `spi_ctrl_port`

## Requirements
- R1: After reset the control word is 0x2000 (overcurrent-shutdown enable, bit 13, high; every other bit low), the reserved-word flag is low and the output enable is low.
- R2: The output enable rises once the select has gone low and stays high until the select returns high. While the enable is low, the serial data output reads 0.
- R3: Bits are sampled on falling serial-clock edges with bit 0 first. A 16-bit frame that is not reserved is copied whole into the control word when the select rises.
- R4: The control word never changes during a frame. It changes only as a result of the select rising.
- R5: The status input is captured when the frame opens. After the k-th rising serial edge of the frame, the data output shows status bit k-1. Changes on the status input during the frame do not alter what is shifted out, and any edges after the 16th shift out 0.
- R6: A frame with fewer or more than 16 falling serial edges is discarded, and the control word keeps its previous value.
- R7: A 16-bit frame equal to 0xF800, 0xE600 or 0xE180 is not applied. It sets the reserved-word flag, which stays high until reset.
- R8: Any other word with bits 15 and 14 both high is applied as an ordinary command.
- R9: Between rising serial edges the data output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock (idles low) |
| csn_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial command data in |
| status_i | input | 16 | Status word presented for read-back |
| sdo_o | output | 1 | Serial status data out |
| sdo_en_o | output | 1 | Output enable for the data pad |
| ctrl_o | output | 16 | Applied control word |
| test_seen_o | output | 1 | Sticky flag: a reserved word was received |

## Verification
The assertions assume that the serial clock and the select never change in the same synchronised cycle. They also assume that the serial clock holds each level for at least two system cycles, so that no edge falls between samples. The stimulus keeps every serial level for eight system cycles and leaves eight cycles between a select change and the next clock edge. The status input is held steady around the moment a frame opens and is then deliberately changed mid-frame. Frames of 15 and 17 bits are included alongside the 16-bit ones.

// File: rtl/spi_port_pkg.sv
// Shared constants for the serial command/status port.
// Assumes a fixed 16-bit command layout with overcurrent-shutdown enable at bit 13.
package spi_port_pkg;
    localparam int          WORD_BITS  = 16;
    localparam logic [15:0] CTRL_RESET = 16'h2000;
    localparam int          N_RESERVED = 3;
    localparam logic [N_RESERVED-1:0][15:0] RESERVED_WORDS = {16'hE180, 16'hE600, 16'hF800};

    // True when the word is one of the reserved test words.
    function automatic logic is_reserved(input logic [15:0] w);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < N_RESERVED; i++) begin
            if (w == RESERVED_WORDS[i]) hit = 1'b1;
        end
        return hit;
    endfunction
endpackage

// File: rtl/spi_sync.sv
// Multi-bit, multi-stage synchroniser. Each bit is treated independently;
// assumes inputs change slowly relative to clk.
module spi_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Move each sample one stage further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= d;
                else             chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rx_shift.sv
// Receive shifter: takes bits LSB first and counts the sampling edges.
// The count saturates at WORD_W+1 so that overlong frames stay distinguishable.
module spi_rx_shift #(
    parameter int WORD_W = 16,
    localparam int CNT_W = $clog2(WORD_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              din,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  count,
    output logic              exact
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

    // Shift a new bit in at the top so that the first bit ends up at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)     word <= '0;
        else if (shift) word <= {din, word[WORD_W-1:1]};
    end

    // Count the sampling edges of the current frame, saturating past full.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                 count <= '0;
        else if (shift && count != CNT_OVER) count <= count + 1'b1;
    end

    assign exact = (count == CNT_FULL);
endmodule

// File: rtl/spi_tx_shift.sv
// Transmit shifter: loads the status snapshot when a frame opens and presents
// one bit per rising serial edge, LSB first, refilling with zeros.
module spi_tx_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              shift,
    output logic              bit_out
);
    logic [WORD_W-1:0] hold;

    // Hold the snapshot and step it one bit at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold <= '0;
        else if (load)  hold <= load_val;
        else if (shift) hold <= hold >> 1;
    end

    // Register the presented bit so it only moves on a shift.
    always_ff @(posedge clk) begin
        if (!rst_n || load) bit_out <= 1'b0;
        else if (shift)     bit_out <= hold[0];
    end
endmodule

// File: rtl/spi_cmd_reg.sv
// Control register with commit-on-release and reserved-word guard.
// Assumes 'apply' pulses once per frame end.
module spi_cmd_reg
    import spi_port_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  logic              frame_ok,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] ctrl,
    output logic              test_seen
);
    logic reserved;
    assign reserved = is_reserved(word);

    // Commit a complete, ordinary command at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctrl <= CTRL_RESET;
        else if (apply && frame_ok && !reserved) ctrl <= word;
    end

    // Remember that a reserved word arrived; cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                             test_seen <= 1'b0;
        else if (apply && frame_ok && reserved) test_seen <= 1'b1;
    end
endmodule

// File: rtl/spi_ctrl_port.sv
// Top of the serial command/status port. Synchronises the serial inputs,
// detects edges, and ties the shifters and control register together.
// Assumes clk runs at least 8x the serial clock, with sclk idling low.
module spi_ctrl_port
    import spi_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk_i,
    input  logic        csn_i,
    input  logic        sdi_i,
    input  logic [15:0] status_i,
    output logic        sdo_o,
    output logic        sdo_en_o,
    output logic [15:0] ctrl_o,
    output logic        test_seen_o
);
    localparam int WORD_W = WORD_BITS;
    localparam int CNT_W  = $clog2(WORD_W + 2);

    logic             csn_s, sclk_s, sdi_s;
    logic             csn_d, sclk_d;
    logic             cs_fall, cs_rise, sclk_fall, sclk_rise;
    logic             frame_on;
    logic             tx_bit;
    logic [WORD_W-1:0] rx_word;
    logic [CNT_W-1:0]  rx_count;
    logic             rx_exact;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({csn_i, sclk_i, sdi_i}),
        .q    ({csn_s, sclk_s, sdi_s})
    );

    // Keep the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_d  <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            csn_d  <= csn_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall   =  csn_d && !csn_s;
    assign cs_rise   = !csn_d &&  csn_s;
    assign sclk_fall =  sclk_d && !sclk_s && frame_on;
    assign sclk_rise = !sclk_d &&  sclk_s && frame_on;

    // Track whether a frame is open; this also drives the pad enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       frame_on <= 1'b0;
        else if (cs_fall) frame_on <= 1'b1;
        else if (cs_rise) frame_on <= 1'b0;
    end

    spi_rx_shift #(.WORD_W(WORD_W)) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cs_fall),
        .shift(sclk_fall),
        .din  (sdi_s),
        .word (rx_word),
        .count(rx_count),
        .exact(rx_exact)
    );

    spi_tx_shift #(.WORD_W(WORD_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cs_fall),
        .load_val(status_i),
        .shift   (sclk_rise),
        .bit_out (tx_bit)
    );

    spi_cmd_reg #(.WORD_W(WORD_W)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply    (cs_rise),
        .frame_ok (rx_exact),
        .word     (rx_word),
        .ctrl     (ctrl_o),
        .test_seen(test_seen_o)
    );

    assign sdo_en_o = frame_on;
    assign sdo_o    = frame_on ? tx_bit : 1'b0;
endmodule

// File: rtl/spi_port_checker.sv
// Property checker for spi_ctrl_port, attached by bind below.
// Assumes sclk and csn never toggle in the same synchronised cycle.
module spi_port_checker
    import spi_port_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        csn_s,
    input logic        csn_d,
    input logic        cs_rise,
    input logic        sclk_rise,
    input logic        tx_bit,
    input logic        rx_exact,
    input logic [15:0] rx_word,
    input logic        sdo_en_o,
    input logic [15:0] ctrl_o,
    input logic        test_seen_o
);
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_s && csn_d) |-> !sdo_en_o); // R2

    AST_CTRL_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_o) |-> $past(cs_rise)); // R4

    AST_SHORT_LONG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !rx_exact) |=> $stable(ctrl_o)); // R6

    AST_RESERVED_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && rx_exact && is_reserved(rx_word)) |=> ($stable(ctrl_o) && test_seen_o)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(test_seen_o) |-> test_seen_o); // R7

    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_en_o && $past(sdo_en_o) && !$stable(tx_bit)) |-> $past(sclk_rise)); // R9
endmodule

bind spi_ctrl_port spi_port_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csn_s      (csn_s),
    .csn_d      (csn_d),
    .cs_rise    (cs_rise),
    .sclk_rise  (sclk_rise),
    .tx_bit     (tx_bit),
    .rx_exact   (rx_exact),
    .rx_word    (rx_word),
    .sdo_en_o   (sdo_en_o),
    .ctrl_o     (ctrl_o),
    .test_seen_o(test_seen_o)
);

// File: tb/test_spi_ctrl_port.sv
// Bench for spi_ctrl_port: behavioural frame driver plus a per-clock model
// of the control word and flag, fed by a queue of timed expectations.
module test_spi_ctrl_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_i = 1'b0;
    logic        csn_i = 1'b1;
    logic        sdi_i = 1'b0;
    logic [15:0] status_i = '0;
    logic        sdo_o, sdo_en_o, test_seen_o;
    logic [15:0] ctrl_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit model_on = 1'b0;
    bit finished = 1'b0;

    logic [15:0] exp_ctrl = 16'h2000;
    bit          exp_flag = 1'b0;
    int          q_cyc[$];
    logic [15:0] q_ctrl[$];
    bit          q_flag[$];

    localparam int HALF = 8;   // system cycles per serial half period
    localparam int LAT  = 3;   // two sync stages plus the edge register

    spi_ctrl_port i_spi_ctrl_port (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i), .sdi_i(sdi_i),
        .status_i(status_i), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o),
        .ctrl_o(ctrl_o), .test_seen_o(test_seen_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-clock model: retire queued updates that are due, then compare.
    always @(negedge clk) begin
        if (model_on && !finished) begin
            while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
                void'(q_cyc.pop_front());
                exp_ctrl = q_ctrl.pop_front();
                exp_flag = q_flag.pop_front();
            end
            check(ctrl_o == exp_ctrl, "R3/R4 control word", ctrl_o, exp_ctrl);
            check(test_seen_o == exp_flag, "R7 reserved flag", {15'd0, test_seen_o}, {15'd0, exp_flag});
        end
    end

    function automatic bit reserved_word(input logic [15:0] w);
        return (w == 16'hF800) || (w == 16'hE600) || (w == 16'hE180);
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Run one frame of nbits clocks, checking the read-back bits against st.
    task automatic frame(input logic [15:0] w, input logic [15:0] st, input int nbits, input string req);
        logic [15:0] nc;
        bit          nf;
        status_i = st;
        wait_cyc(2);
        csn_i = 1'b0;
        wait_cyc(HALF);
        check(sdo_en_o == 1'b1, "R2 enable in frame", {15'd0, sdo_en_o}, 16'd1);
        for (int i = 0; i < nbits; i++) begin
            sclk_i = 1'b1;
            sdi_i  = (i < 16) ? w[i] : 1'b0;
            if (i == 1) status_i = ~st;   // R5: late change must not leak
            wait_cyc(HALF);
            check(sdo_o == ((i < 16) ? st[i] : 1'b0), {"R5 read-back ", req},
                  {15'd0, sdo_o}, {15'd0, (i < 16) ? st[i] : 1'b0});
            sclk_i = 1'b0;
            wait_cyc(HALF);
        end
        csn_i = 1'b1;
        nc = exp_ctrl;
        nf = exp_flag;
        if (q_ctrl.size() > 0) begin
            nc = q_ctrl[$];
            nf = q_flag[$];
        end
        if (nbits == 16 && reserved_word(w)) nf = 1'b1;
        else if (nbits == 16)                nc = w;
        q_cyc.push_back(cyc + LAT);
        q_ctrl.push_back(nc);
        q_flag.push_back(nf);
        wait_cyc(HALF);
        check(sdo_en_o == 1'b0, "R2 enable after frame", {15'd0, sdo_en_o}, 16'd0);
        check(sdo_o == 1'b0, "R2 idle data", {15'd0, sdo_o}, 16'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait_cyc(150000);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(1);
        check(ctrl_o == 16'h2000, "R1 reset control", ctrl_o, 16'h2000);
        check(test_seen_o == 1'b0, "R1 reset flag", {15'd0, test_seen_o}, 16'd0);
        check(sdo_en_o == 1'b0, "R1 reset enable", {15'd0, sdo_en_o}, 16'd0);
        model_on = 1'b1;

        frame(16'h007E, 16'hA5C3, 16, "R3 all switches");
        frame(16'h0001, 16'h6001, 16, "R3 status reset");
        frame(16'h1234, 16'h8421, 15, "R6 short frame");
        frame(16'h4321, 16'h0F0F, 17, "R6 long frame");
        frame(16'hF800, 16'hFFFF, 16, "R7 reserved A");
        frame(16'hE600, 16'h0000, 16, "R7 reserved B");
        frame(16'hE180, 16'h1357, 16, "R7 reserved C");
        frame(16'hC000, 16'h2468, 16, "R8 high bits plain");
        frame(16'hE02A, 16'h8001, 16, "R8 near reserved");
        frame(16'h2054, 16'h7FFE, 16, "R7 flag stays after normal");
        wait_cyc(10);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule